// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is the control core of a queued serial master. Software programs a first and a last queue index and sets the run enable. The sequencer then issues one transfer request per queue entry to an external shift engine and waits for its completion pulse before it moves to the next index. Index arithmetic is modulo the queue size, so a first index above the last index walks through the top entry and on to zero.

In loop mode the sequencer returns to the first index after the last entry and keeps running, so receive data from each new pass replaces the previous pass. It can stop in three ways. Clearing loop mode stops it at the next queue end. A pause request parks it after the current transfer. Dropping the run enable stops it at once and cancels the transfer in flight. Mode-fault logic watches a synchronized slave-select input and shuts the unit down when another master appears to drive that line. The two sticky status flags clear only after a status read followed by a write of zero.

Top module: `qspi_queue_seq`

States: IDLE (waiting for enable), LAUNCH (one-cycle transfer request), WAIT (transfer in flight), HALT (paused). Transitions:
- IDLE->LAUNCH when enabled, loading the first index.
- LAUNCH->WAIT.
- WAIT->LAUNCH on done when more entries remain, or at the end in loop mode.
- WAIT->HALT on done with pause requested.
- WAIT->IDLE at the end without loop mode.
- HALT->LAUNCH when the pause request is withdrawn.
- Any state->IDLE when the enable is low.

## Requirements
- R1: After reset the enable, both flags, the pause indicator, the index and all handshake outputs are 0, and port_ctl is 1.
- R2: Once enabled, `xfer_start` pulses for one cycle per entry, beginning at `ctl_first`. `xfer_ptr`/`sts_ptr` advance by one on each `xfer_done` received in WAIT.
- R3: When `xfer_done` arrives for the entry at `ctl_last` without loop mode, `sts_fin` sets, `run_en` clears and no further transfer starts.
- R4: With `ctl_wrap`=1, the entry after `ctl_last` is `ctl_first`. `run_en` stays 1 and `sts_fin` still sets at every queue end.
- R5: Rewriting the control register with `ctl_wrap`=0 during a looping run makes the next queue end behave as R3.
- R6: With `ctl_halt`=1, the transfer in flight completes. The sequencer then enters HALT (`sts_halted`=1) and issues no start until the request is withdrawn or the enable is cleared.
- R7: Clearing the enable while a transfer is in flight produces a one-cycle `xfer_abort` and returns to IDLE.
- R8: A mode fault sets `sts_modf` only when `ctl_master`=1, `ctl_ss_out`=0 and `ss_n_in` is low after a two-flop synchronizer. The flag is set at the third rising edge that samples the low level.
- R9: A mode fault clears `run_en` and drives `port_ctl` to 1. `irq` = `ctl_irq_en` AND (`sts_modf` OR `sts_halted`).
- R10: A flag clears only on a status write with a 0 in its bit (bit 0 = fin, bit 1 = modf) that follows a status read made while the flag was set. A write with no such read leaves it set.
- R11: With `ctl_ss_out`=1 the slave-select level is ignored and `sts_modf` never sets.
- R12: The index increments modulo 16, so a queue with `ctl_first` > `ctl_last` runs through 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Run enable written value |
| ctl_wrap | input | 1 | Loop mode |
| ctl_halt | input | 1 | Pause request |
| ctl_master | input | 1 | Master mode select |
| ctl_ss_out | input | 1 | Slave-select pin is an output (1) or input (0) |
| ctl_irq_en | input | 1 | Pause/fault interrupt enable |
| ctl_first | input | 4 | First queue index |
| ctl_last | input | 4 | Last queue index |
| sts_rd | input | 1 | Status read strobe |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Status write data (bit0 fin, bit1 modf) |
| ss_n_in | input | 1 | Slave-select input level (asynchronous) |
| xfer_done | input | 1 | Transfer engine completion pulse |
| xfer_start | output | 1 | Transfer request pulse |
| xfer_abort | output | 1 | Cancel in-flight transfer |
| xfer_ptr | output | 4 | Queue index of the requested transfer |
| run_en | output | 1 | Current run enable |
| sts_fin | output | 1 | Queue-end flag |
| sts_modf | output | 1 | Mode-fault flag |
| sts_halted | output | 1 | Sequencer is paused |
| sts_ptr | output | 4 | Current queue index |
| port_ctl | output | 1 | Serial pins under general port control |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state or index shows up at the ports within one or two cycles. The next `xfer_start` appears too early, too late or with the wrong `xfer_ptr`, or `run_en` and `sts_fin` change at the wrong completion. A broken flag-clear qualifier shows up at the first write, when a flag survives a valid clear or disappears on an unarmed one. A broken synchronizer or fault qualifier moves the `sts_modf` edge away from the third sampling edge, or sets the flag when the pin is an output. The reference model compares every output on every cycle, so any of these shows up in the first cycle that differs.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_HALT   = 2'd3
    } seq_state_e;

    localparam int STS_FIN_BIT  = 0;
    localparam int STS_MODF_BIT = 1;
    localparam int STS_FLAGS    = 2;
endpackage

// File: rtl/qseq_sync.sv
module qseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qseq_status.sv
module qseq_status #(
    parameter int NFLAGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [NFLAGS-1:0] wdata_i,
    output logic [NFLAGS-1:0] flag_o
);
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        logic flag_q, armed_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (set_i[g])
                    flag_q <= 1'b1;
                else if (wr_i && armed_q && !wdata_i[g])
                    flag_q <= 1'b0;
                if (rd_i)
                    armed_q <= flag_q;
                else if (wr_i)
                    armed_q <= 1'b0;
            end
        end

        assign flag_o[g] = flag_q;
    end
endmodule

// File: rtl/qspi_queue_seq.sv
module qspi_queue_seq
    import qseq_pkg::*;
#(
    parameter int PTR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic             ctl_wrap,
    input  logic             ctl_halt,
    input  logic             ctl_master,
    input  logic             ctl_ss_out,
    input  logic             ctl_irq_en,
    input  logic [PTR_W-1:0] ctl_first,
    input  logic [PTR_W-1:0] ctl_last,
    input  logic             sts_rd,
    input  logic             sts_wr,
    input  logic [1:0]       sts_wdata,
    input  logic             ss_n_in,
    input  logic             xfer_done,
    output logic             xfer_start,
    output logic             xfer_abort,
    output logic [PTR_W-1:0] xfer_ptr,
    output logic             run_en,
    output logic             sts_fin,
    output logic             sts_modf,
    output logic             sts_halted,
    output logic [PTR_W-1:0] sts_ptr,
    output logic             port_ctl,
    output logic             irq
);
    seq_state_e       state_q, state_d;
    logic [PTR_W-1:0] cur_q, cur_d;
    logic [PTR_W-1:0] first_q, last_q;
    logic             en_q, wrap_q, halt_q, master_q, ss_out_q, irqen_q;
    logic             ss_sync, fault_det, at_end, done_ok, stop_evt;
    logic [STS_FLAGS-1:0] flag_set, flags;

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_q   <= 1'b0;
            halt_q   <= 1'b0;
            master_q <= 1'b0;
            ss_out_q <= 1'b0;
            irqen_q  <= 1'b0;
            first_q  <= '0;
            last_q   <= '0;
        end else if (ctl_we) begin
            wrap_q   <= ctl_wrap;
            halt_q   <= ctl_halt;
            master_q <= ctl_master;
            ss_out_q <= ctl_ss_out;
            irqen_q  <= ctl_irq_en;
            first_q  <= ctl_first;
            last_q   <= ctl_last;
        end
    end

    qseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ss_n_in),
        .dout (ss_sync)
    );

    assign fault_det = master_q && !ss_out_q && !ss_sync;
    assign at_end    = (cur_q == last_q);
    assign done_ok   = (state_q == SEQ_WAIT) && en_q && xfer_done;
    assign stop_evt  = done_ok && at_end && !wrap_q;

    // Run enable: hardware clears win over a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     en_q <= 1'b0;
        else if (fault_det || stop_evt) en_q <= 1'b0;
        else if (ctl_we)                en_q <= ctl_enable;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (en_q) begin
                    state_d = SEQ_LAUNCH;
                    cur_d   = first_q;
                end
            end
            SEQ_LAUNCH: begin
                state_d = en_q ? SEQ_WAIT : SEQ_IDLE;
            end
            SEQ_WAIT: begin
                if (!en_q) begin
                    state_d = SEQ_IDLE;
                end else if (xfer_done) begin
                    if (at_end && !wrap_q) begin
                        state_d = SEQ_IDLE;
                    end else begin
                        cur_d   = at_end ? first_q : cur_q + 1'b1;
                        state_d = halt_q ? SEQ_HALT : SEQ_LAUNCH;
                    end
                end
            end
            SEQ_HALT: begin
                if (!en_q)        state_d = SEQ_IDLE;
                else if (!halt_q) state_d = SEQ_LAUNCH;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    assign flag_set[STS_FIN_BIT]  = done_ok && at_end;
    assign flag_set[STS_MODF_BIT] = fault_det;

    qseq_status #(.NFLAGS(STS_FLAGS)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .rd_i   (sts_rd),
        .wr_i   (sts_wr),
        .wdata_i(sts_wdata),
        .flag_o (flags)
    );

    // Outputs
    always_comb begin
        xfer_start = (state_q == SEQ_LAUNCH) && en_q;
        xfer_abort = (state_q == SEQ_WAIT) && !en_q;
        xfer_ptr   = cur_q;
        sts_ptr    = cur_q;
        run_en     = en_q;
        sts_fin    = flags[STS_FIN_BIT];
        sts_modf   = flags[STS_MODF_BIT];
        sts_halted = (state_q == SEQ_HALT);
        port_ctl   = !en_q || flags[STS_MODF_BIT];
        irq        = irqen_q && (flags[STS_MODF_BIT] || (state_q == SEQ_HALT));
    end
endmodule

// File: rtl/qseq_chk.sv
module qseq_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_start,
    input logic xfer_abort,
    input logic run_en,
    input logic sts_fin,
    input logic sts_modf,
    input logic sts_halted,
    input logic sts_wr,
    input logic ss_out_q
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_halted |-> !xfer_start);

    // R7
    abort_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> !run_en);

    // R9
    fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_modf) |-> !run_en);

    // R10
    fin_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_fin) |-> $past(sts_wr));

    // R11
    ss_output_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_modf && ss_out_q) |=> !sts_modf);
endmodule

bind qspi_queue_seq qseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_start(xfer_start),
    .xfer_abort(xfer_abort),
    .run_en    (run_en),
    .sts_fin   (sts_fin),
    .sts_modf  (sts_modf),
    .sts_halted(sts_halted),
    .sts_wr    (sts_wr),
    .ss_out_q  (ss_out_q)
);

// File: tb/qspi_queue_seq_test.sv
module qspi_queue_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_enable = 0, ctl_wrap = 0, ctl_halt = 0;
    logic ctl_master = 0, ctl_ss_out = 0, ctl_irq_en = 0;
    logic [3:0] ctl_first = 0, ctl_last = 0;
    logic sts_rd = 0, sts_wr = 0;
    logic [1:0] sts_wdata = 0;
    logic ss_n_in = 1, xfer_done = 0;
    logic xfer_start, xfer_abort, run_en, sts_fin, sts_modf, sts_halted, port_ctl, irq;
    logic [3:0] xfer_ptr, sts_ptr;

    qspi_queue_seq uut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Reference model: modes 0 idle, 1 launch, 2 wait, 3 halt
    int  m_mode = 0, m_cur = 0, m_first = 0, m_last = 0;
    bit  m_en, m_fin, m_modf, m_arm_fin, m_arm_modf;
    bit  m_wrap, m_halt, m_master, m_ssout, m_irqen;
    int  ssq[$] = '{1, 1};
    int  n_mode, n_cur;
    bit  n_en, fault, endhit, doneok;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cur = 0; m_first = 0; m_last = 0;
            m_en = 0; m_fin = 0; m_modf = 0; m_arm_fin = 0; m_arm_modf = 0;
            m_wrap = 0; m_halt = 0; m_master = 0; m_ssout = 0; m_irqen = 0;
            ssq = '{1, 1};
        end else begin
            fault  = m_master && !m_ssout && (ssq[0] == 0);
            void'(ssq.pop_front());
            ssq.push_back(int'(ss_n_in));
            endhit = (m_cur == m_last);
            doneok = (m_mode == 2) && m_en && xfer_done;
            n_mode = m_mode; n_cur = m_cur;
            if (m_mode == 0 && m_en) begin n_mode = 1; n_cur = m_first; end
            else if (m_mode == 1) n_mode = m_en ? 2 : 0;
            else if (m_mode == 2) begin
                if (!m_en) n_mode = 0;
                else if (xfer_done) begin
                    if (endhit && !m_wrap) n_mode = 0;
                    else begin
                        n_cur  = endhit ? m_first : (m_cur + 1) % 16;
                        n_mode = m_halt ? 3 : 1;
                    end
                end
            end else if (m_mode == 3) begin
                if (!m_en) n_mode = 0;
                else if (!m_halt) n_mode = 1;
            end
            n_en = ctl_we ? ctl_enable : m_en;
            if (fault || (doneok && endhit && !m_wrap)) n_en = 0;
            // flags and arming
            if (sts_wr && m_arm_fin && !sts_wdata[0]) m_fin = 0;
            if (sts_wr && m_arm_modf && !sts_wdata[1]) m_modf = 0;
            if (sts_rd) begin m_arm_fin = m_fin; m_arm_modf = m_modf; end
            else if (sts_wr) begin m_arm_fin = 0; m_arm_modf = 0; end
            if (doneok && endhit) m_fin = 1;
            if (fault) m_modf = 1;
            if (ctl_we) begin
                m_wrap = ctl_wrap; m_halt = ctl_halt; m_master = ctl_master;
                m_ssout = ctl_ss_out; m_irqen = ctl_irq_en;
                m_first = ctl_first; m_last = ctl_last;
            end
            m_mode = n_mode; m_cur = n_cur; m_en = n_en;
        end
    end

    // Per-cycle comparison
    always @(negedge clk) if (rst_n) begin
        chk("R2 xfer_start", xfer_start, (m_mode == 1 && m_en));
        chk("R2 ptr", sts_ptr, m_cur);
        chk("R2 xfer_ptr", xfer_ptr, m_cur);
        chk("R7 xfer_abort", xfer_abort, (m_mode == 2 && !m_en));
        chk("R3 run_en", run_en, m_en);
        chk("R3 sts_fin", sts_fin, m_fin);
        chk("R8 sts_modf", sts_modf, m_modf);
        chk("R6 sts_halted", sts_halted, (m_mode == 3));
        chk("R9 port_ctl", port_ctl, (!m_en || m_modf));
        chk("R9 irq", irq, (m_irqen && (m_modf || m_mode == 3)));
    end

    // Transfer engine stand-in and monitors
    int busy = 0, starts = 0, aborts = 0, last_ptr = -1;
    bit saw_top_roll = 0, saw_restart = 0;
    always @(negedge clk) begin
        xfer_done <= 1'b0;
        if (busy > 0) begin
            busy--;
            if (busy == 0) xfer_done <= 1'b1;
        end
        if (xfer_abort) begin busy = 0; aborts++; end
        if (xfer_start) begin
            busy = 3;
            starts++;
            if (last_ptr == 15 && xfer_ptr == 0) saw_top_roll = 1;
            if (last_ptr == 1 && xfer_ptr == 14) saw_restart = 1;
            last_ptr = int'(xfer_ptr);
        end
    end

    task automatic cw(bit en, bit wr, bit hl, bit ms, bit so, bit ie, int f, int l);
        @(negedge clk);
        ctl_we = 1; ctl_enable = en; ctl_wrap = wr; ctl_halt = hl;
        ctl_master = ms; ctl_ss_out = so; ctl_irq_en = ie;
        ctl_first = 4'(f); ctl_last = 4'(l);
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic srd();
        @(negedge clk); sts_rd = 1;
        @(negedge clk); sts_rd = 0;
    endtask

    task automatic swr(logic [1:0] d);
        @(negedge clk); sts_wr = 1; sts_wdata = d;
        @(negedge clk); sts_wr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off(int lim);
        for (int i = 0; i < lim && run_en; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        wrap_up();
    end

    initial begin
        int s0;
        idle(2);
        chk("R1 run_en", run_en, 0);
        chk("R1 sts_fin", sts_fin, 0);
        chk("R1 ptr", sts_ptr, 0);
        chk("R1 port_ctl", port_ctl, 1);
        rst_n = 1;
        idle(2);

        // R2 R3: one pass over entries 2..4
        cw(1, 0, 0, 1, 1, 0, 2, 4);
        wait_off(100);
        idle(3);
        chk("R2 start count", starts, 3);
        chk("R3 last ptr", last_ptr, 4);
        chk("R3 fin set", sts_fin, 1);
        chk("R3 stopped", run_en, 0);

        // R10: write without read, then read-then-write
        swr(2'b00); idle(1);
        chk("R10 unarmed write", sts_fin, 1);
        srd(); swr(2'b00); idle(1);
        chk("R10 armed clear", sts_fin, 0);

        // R4 R12: looping queue 14..1
        starts = 0;
        cw(1, 1, 0, 1, 1, 0, 14, 1);
        idle(80);
        chk("R4 still enabled", run_en, 1);
        chk("R4 restart seen", saw_restart, 1);
        chk("R12 15 to 0", saw_top_roll, 1);
        chk("R4 many starts", int'(starts > 6), 1);

        // R5: drop loop mode
        cw(1, 0, 0, 1, 1, 0, 14, 1);
        wait_off(100);
        idle(3);
        chk("R5 stopped", run_en, 0);
        chk("R5 last ptr", last_ptr, 1);
        chk("R5 fin", sts_fin, 1);
        srd(); swr(2'b00);

        // R6: pause request
        cw(1, 0, 0, 1, 1, 1, 0, 15);
        idle(10);
        cw(1, 0, 1, 1, 1, 1, 0, 15);
        for (int i = 0; i < 20 && !sts_halted; i++) @(negedge clk);
        chk("R6 halted", sts_halted, 1);
        chk("R6 irq", irq, 1);
        s0 = starts;
        idle(10);
        chk("R6 no start", starts, s0);
        cw(0, 0, 0, 1, 1, 1, 0, 15);
        idle(2);
        chk("R6 left halt", sts_halted, 0);

        // R7: abortive disable
        aborts = 0;
        cw(1, 0, 0, 1, 1, 0, 0, 15);
        do @(negedge clk); while (!xfer_start);
        cw(0, 0, 0, 1, 1, 0, 0, 15);
        idle(3);
        chk("R7 abort", aborts, 1);
        chk("R7 disabled", run_en, 0);

        // R8 R9: mode fault
        cw(1, 0, 0, 1, 0, 1, 0, 15);
        idle(5);
        ss_n_in = 0;
        idle(4);
        chk("R8 modf", sts_modf, 1);
        chk("R9 en cleared", run_en, 0);
        chk("R9 port_ctl", port_ctl, 1);
        chk("R9 irq", irq, 1);
        ss_n_in = 1;
        idle(3);
        swr(2'b00); idle(1);
        chk("R10 modf unarmed", sts_modf, 1);
        srd(); swr(2'b01); idle(1);
        chk("R10 modf cleared", sts_modf, 0);

        // R11: pin as output
        cw(0, 0, 0, 1, 1, 0, 0, 0);
        ss_n_in = 0; idle(6);
        chk("R11 no modf", sts_modf, 0);
        ss_n_in = 1; idle(3);

        // R8: slave mode ignores pin
        cw(0, 0, 0, 0, 0, 0, 0, 0);
        ss_n_in = 0; idle(6);
        chk("R8 slave no modf", sts_modf, 0);
        ss_n_in = 1; idle(3);

        wrap_up();
    end
endmodule